// File: doc/BRIEF.md
# SPI Master with Counted FIFO Transfers

This block is a memory-mapped SPI master. Software pushes transmit words into a 16-entry TX FIFO and pops received words from a 16-entry RX FIFO. Two separate 32-bit word counters control each transfer. When a counter is zero, its direction is idle. A transmit-only or receive-only transfer therefore needs no dummy traffic. Each direction raises its own completion flag when its last counted word has gone through the shifter.

The shift engine moves one word of 1 to 32 bits at a time. Polarity, phase, bit order and a clock divider are all programmable. The engine starts a word only when the FIFOs allow it. If they do not, SCK waits at its idle level. Chip-select is a plain register bit that software controls.

The bus is a single-cycle register port. Writes take effect at the clock edge. Read data is combinational from the address. A read of the RX data register pops the FIFO at the same edge. Byte offsets are: control 0x00, config 0x04, status 0x08, pin 0x0C, TX data 0x10, RX data 0x14, divider 0x18, TX count 0x1C, RX count 0x20.

Top module: `spi_master`

## Requirements
- R1: After reset, csN is 1, sclk is 0 and the status register at 0x08 reads 0x0010_0000, which means both FIFOs are empty and no flag is set.
- R2: The word length is set by config bits 13:8 and may be any value from 1 to 32. Data is right-aligned, so a looped-back word comes back in RX data (0x14) equal to the sent word masked to its length. Each word produces exactly that many sampling edges.
- R3: Config bit 1 (CPOL) sets the idle level of SCK, and SCK returns to it between words. Config bit 0 (CPHA) selects the sampling edge: 0 samples on the leading edge, 1 samples on the trailing edge.
- R4: Config bit 2 set sends and receives the least significant bit first. When it is clear, the most significant bit of the word goes first.
- R5: Each SCK half-period lasts D clock cycles, where D is the divider at 0x18 (bits 10:0). A value of 0 acts as 1.
- R6: Each FIFO holds 16 words. Status reports the TX level in bits 15:8, TX full in bit 4, RX empty in bit 20 and the RX level in bits 31:24. A write to 0x10 while TX is full is dropped and sets the sticky bit 2.
- R7: A read of 0x14 while RX is empty returns 0 and sets the sticky status bit 3.
- R8: The counts are written at 0x1C (TX) and 0x20 (RX), and a count of 0 disables that direction. With RX disabled, received bits are dropped. Once the TX count is used up while RX words remain, MOSI sends 0.
- R9: Status bit 0 is set when the last counted TX word finishes, and bit 1 when the last counted RX word is stored. Writing 1 to any of status bits 3:0 clears that bit.
- R10: A word starts only when TX holds data (or TX is disabled) and RX has room (or RX is disabled). While it waits, SCK stays at its idle level, and pops from RX let the transfer go on.
- R11: Control bit 0 is run. Words written while run is 0 are not shifted, and they are sent once run is set. Clearing run lets the current word finish and starts no more words.
- R12: Writing 1 to control bit 2 empties the TX FIFO, and writing 1 to bit 3 empties the RX FIFO.
- R13: Bit 0 of the pin register at 0x0C drives csN directly, and csN changes only on a write to that register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busWe | input | 1 | Register write strobe |
| busRe | input | 1 | Register read strobe (pops RX on 0x14) |
| busAddr | input | 6 | Byte address of the register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, combinational from busAddr |
| miso | input | 1 | Serial data in |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| csN | output | 1 | Chip-select, software driven |

## Verification
Two events can land in the same cycle: the host pops the RX FIFO while the engine stores a finished word, and the host pushes into TX while the engine takes a word out. The bench provokes the first with a receive-only transfer of 20 words. The RX FIFO fills up and the engine stalls. The host then drains it with back-to-back reads while the engine resumes. The run passes if every word comes back right, the level and the done flag are right at the end, and SCK stays idle during the stall. A sweep over the four modes, both bit orders, five word lengths and three divider values checks loopback data, the bit order seen on MOSI, the edge count and the half-period.

// File: rtl/spi_master_pkg.sv
package spi_master_pkg;
  localparam int WORD_BITS_W = 6;
  localparam int DIV_W = 11;

  localparam logic [3:0] REG_CTRL  = 4'd0;
  localparam logic [3:0] REG_CFG   = 4'd1;
  localparam logic [3:0] REG_STAT  = 4'd2;
  localparam logic [3:0] REG_PIN   = 4'd3;
  localparam logic [3:0] REG_TXD   = 4'd4;
  localparam logic [3:0] REG_RXD   = 4'd5;
  localparam logic [3:0] REG_DIV   = 4'd6;
  localparam logic [3:0] REG_TXCNT = 4'd7;
  localparam logic [3:0] REG_RXCNT = 4'd8;

  typedef struct packed {
    logic                   cpha;
    logic                   cpol;
    logic                   lsbFirst;
    logic [WORD_BITS_W-1:0] wordBits;
    logic [DIV_W-1:0]       clkDiv;
  } spiCfg_t;

  typedef struct packed {
    logic wordStart;
    logic txPop;
    logic txPush;
    logic txFlush;
    logic rxPush;
    logic rxPop;
    logic rxFlush;
  } spiStrobe_t;
endpackage

// File: rtl/spi_fifo.sv
module spi_fifo #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             flush,
  input  logic             push,
  input  logic [WIDTH-1:0] wdata,
  input  logic             pop,
  output logic [WIDTH-1:0] rdata,
  output logic [LW-1:0]    level
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;

  function automatic logic [AW-1:0] nextPtr(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wrPtr] <= wdata;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else if (flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else begin
      if (push) wrPtr <= nextPtr(wrPtr);
      if (pop)  rdPtr <= nextPtr(rdPtr);
      level <= level + LW'(push) - LW'(pop);
    end
  end

  assign rdata = mem[rdPtr];
endmodule

// File: rtl/spi_datapath.sv
module spi_datapath
  import spi_master_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int FIFO_DEPTH = 16,
  localparam int LW = $clog2(FIFO_DEPTH + 1),
  localparam int BIT_W = $clog2(WORD_W) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  spiCfg_t           cfg,
  input  spiStrobe_t        strb,
  input  logic [WORD_W-1:0] txWdata,
  input  logic              miso,
  output logic              sclk,
  output logic              mosi,
  output logic [WORD_W-1:0] rxRdata,
  output logic [LW-1:0]     txLevel,
  output logic [LW-1:0]     rxLevel,
  output logic              busy,
  output logic              wordDone
);
  logic [WORD_W-1:0] txHead, txWord, rxSh, loaded;
  logic [BIT_W-1:0]  nEff, bitIdx;
  logic [DIV_W-1:0]  divEff, halfCnt;
  logic              active, phase;

  spi_fifo #(.WIDTH(WORD_W), .DEPTH(FIFO_DEPTH)) u_txFifo (
    .clk(clk), .rstN(rstN), .flush(strb.txFlush), .push(strb.txPush),
    .wdata(txWdata), .pop(strb.txPop), .rdata(txHead), .level(txLevel));

  spi_fifo #(.WIDTH(WORD_W), .DEPTH(FIFO_DEPTH)) u_rxFifo (
    .clk(clk), .rstN(rstN), .flush(strb.rxFlush), .push(strb.rxPush),
    .wdata(rxSh), .pop(strb.rxPop), .rdata(rxRdata), .level(rxLevel));

  always_comb begin
    if (cfg.wordBits == '0) nEff = BIT_W'(1);
    else if (BIT_W'(cfg.wordBits) > BIT_W'(WORD_W)) nEff = BIT_W'(WORD_W);
    else nEff = BIT_W'(cfg.wordBits);
    divEff = (cfg.clkDiv == '0) ? DIV_W'(1) : cfg.clkDiv;
    loaded = strb.txPop ? txHead : '0;
  end

  // Index the word instead of shifting it; order picks the index.
  function automatic logic pickBit(input logic [WORD_W-1:0] w, input logic [BIT_W-1:0] i,
                                   input logic [BIT_W-1:0] n, input logic lsb);
    logic [BIT_W-1:0] k;
    k = lsb ? i : (n - BIT_W'(1) - i);
    return w[k[BIT_W-2:0]];
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active <= 1'b0; phase <= 1'b0; wordDone <= 1'b0;
      sclk <= 1'b0; mosi <= 1'b0;
      halfCnt <= '0; bitIdx <= '0; txWord <= '0; rxSh <= '0;
    end else begin
      wordDone <= 1'b0;
      if (!active) sclk <= cfg.cpol;
      if (strb.wordStart) begin
        active <= 1'b1; phase <= 1'b0; halfCnt <= '0; bitIdx <= '0;
        txWord <= loaded; rxSh <= '0;
        if (!cfg.cpha) mosi <= pickBit(loaded, '0, nEff, cfg.lsbFirst);
      end else if (active) begin
        if (halfCnt == divEff - DIV_W'(1)) begin
          halfCnt <= '0;
          sclk <= ~sclk;
          if (!phase) begin
            phase <= 1'b1;
            if (cfg.cpha) mosi <= pickBit(txWord, bitIdx, nEff, cfg.lsbFirst);
            else if (cfg.lsbFirst) rxSh[bitIdx[BIT_W-2:0]] <= miso;
            else rxSh <= {rxSh[WORD_W-2:0], miso};
          end else begin
            phase <= 1'b0;
            if (cfg.cpha) begin
              if (cfg.lsbFirst) rxSh[bitIdx[BIT_W-2:0]] <= miso;
              else rxSh <= {rxSh[WORD_W-2:0], miso};
            end
            if (bitIdx == nEff - BIT_W'(1)) begin
              active <= 1'b0;
              wordDone <= 1'b1;
            end else begin
              bitIdx <= bitIdx + BIT_W'(1);
              if (!cfg.cpha) mosi <= pickBit(txWord, bitIdx + BIT_W'(1), nEff, cfg.lsbFirst);
            end
          end
        end else begin
          halfCnt <= halfCnt + DIV_W'(1);
        end
      end
    end
  end

  assign busy = active | wordDone;
endmodule

// File: rtl/spi_ctrl.sv
module spi_ctrl
  import spi_master_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int FIFO_DEPTH = 16,
  localparam int LW = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWe,
  input  logic              busRe,
  input  logic [5:0]        busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  output spiCfg_t           cfg,
  output spiStrobe_t        strb,
  output logic              csN,
  input  logic [LW-1:0]     txLevel,
  input  logic [LW-1:0]     rxLevel,
  input  logic              busy,
  input  logic              wordDone,
  input  logic [WORD_W-1:0] rxRdata
);
  logic [3:0] idx;
  logic run, txDone, rxDone, txOvf, rxUnd;
  logic wordTxLast, wordRxKeep, wordRxLast;
  logic [31:0] txCnt, rxCnt;
  logic txFull, rxEmpty, canStart;
  logic unusedAddrBits;

  assign idx = busAddr[5:2];
  assign unusedAddrBits = ^busAddr[1:0];
  assign txFull = (txLevel == LW'(FIFO_DEPTH));
  assign rxEmpty = (rxLevel == '0);

  // A word starts only with data to send and room to keep what comes back.
  assign canStart = run && !busy && (txCnt != '0 || rxCnt != '0)
                 && (txCnt == '0 || txLevel != '0)
                 && (rxCnt == '0 || rxLevel != LW'(FIFO_DEPTH));

  always_comb begin
    strb.wordStart = canStart;
    strb.txPop     = canStart && (txCnt != '0);
    strb.txPush    = busWe && idx == REG_TXD && !txFull;
    strb.txFlush   = busWe && idx == REG_CTRL && busWdata[2];
    strb.rxPush    = wordDone && wordRxKeep;
    strb.rxPop     = busRe && idx == REG_RXD && !rxEmpty;
    strb.rxFlush   = busWe && idx == REG_CTRL && busWdata[3];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      run <= 1'b0; csN <= 1'b1;
      cfg <= '{cpha: 1'b0, cpol: 1'b0, lsbFirst: 1'b0, wordBits: WORD_BITS_W'(8), clkDiv: DIV_W'(1)};
      txCnt <= '0; rxCnt <= '0;
      txDone <= 1'b0; rxDone <= 1'b0; txOvf <= 1'b0; rxUnd <= 1'b0;
      wordTxLast <= 1'b0; wordRxKeep <= 1'b0; wordRxLast <= 1'b0;
    end else begin
      if (busWe) begin
        case (idx)
          REG_CTRL: run <= busWdata[0];
          REG_CFG: begin
            cfg.cpha <= busWdata[0];
            cfg.cpol <= busWdata[1];
            cfg.lsbFirst <= busWdata[2];
            cfg.wordBits <= busWdata[8 +: WORD_BITS_W];
          end
          REG_DIV: cfg.clkDiv <= busWdata[DIV_W-1:0];
          REG_PIN: csN <= busWdata[0];
          REG_STAT: begin
            if (busWdata[0]) txDone <= 1'b0;
            if (busWdata[1]) rxDone <= 1'b0;
            if (busWdata[2]) txOvf <= 1'b0;
            if (busWdata[3]) rxUnd <= 1'b0;
          end
          default: ;
        endcase
      end
      if (busWe && idx == REG_TXD && txFull) txOvf <= 1'b1;
      if (busRe && idx == REG_RXD && rxEmpty) rxUnd <= 1'b1;

      if (busWe && idx == REG_TXCNT) txCnt <= busWdata;
      else if (strb.txPop) txCnt <= txCnt - 32'd1;
      if (busWe && idx == REG_RXCNT) rxCnt <= busWdata;
      else if (canStart && rxCnt != '0) rxCnt <= rxCnt - 32'd1;

      if (canStart) begin
        wordTxLast <= (txCnt == 32'd1);
        wordRxKeep <= (rxCnt != '0);
        wordRxLast <= (rxCnt == 32'd1);
      end
      if (wordDone && wordTxLast) txDone <= 1'b1;
      if (wordDone && wordRxLast) rxDone <= 1'b1;
    end
  end

  always_comb begin
    busRdata = '0;
    case (idx)
      REG_CTRL:  busRdata = {31'd0, run};
      REG_CFG:   busRdata = {18'd0, cfg.wordBits, 5'd0, cfg.lsbFirst, cfg.cpol, cfg.cpha};
      REG_STAT:  busRdata = {8'(rxLevel), 3'd0, rxEmpty, 4'd0, 8'(txLevel), 3'd0, txFull,
                             rxUnd, txOvf, rxDone, txDone};
      REG_PIN:   busRdata = {31'd0, csN};
      REG_RXD:   busRdata = rxEmpty ? 32'd0 : 32'(rxRdata);
      REG_DIV:   busRdata = 32'(cfg.clkDiv);
      REG_TXCNT: busRdata = txCnt;
      REG_RXCNT: busRdata = rxCnt;
      default:   busRdata = {31'd0, unusedAddrBits & 1'b0};
    endcase
  end
endmodule

// File: rtl/spi_master.sv
module spi_master
  import spi_master_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int FIFO_DEPTH = 16,
  localparam int LW = $clog2(FIFO_DEPTH + 1)
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        busWe,
  input  logic        busRe,
  input  logic [5:0]  busAddr,
  input  logic [31:0] busWdata,
  output logic [31:0] busRdata,
  input  logic        miso,
  output logic        sclk,
  output logic        mosi,
  output logic        csN
);
  spiCfg_t           cfg;
  spiStrobe_t        strb;
  logic [LW-1:0]     txLevel, rxLevel;
  logic              busy, wordDone;
  logic [WORD_W-1:0] rxRdata;

  spi_ctrl #(.WORD_W(WORD_W), .FIFO_DEPTH(FIFO_DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busRe(busRe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .cfg(cfg), .strb(strb), .csN(csN),
    .txLevel(txLevel), .rxLevel(rxLevel), .busy(busy), .wordDone(wordDone),
    .rxRdata(rxRdata));

  spi_datapath #(.WORD_W(WORD_W), .FIFO_DEPTH(FIFO_DEPTH)) u_data (
    .clk(clk), .rstN(rstN), .cfg(cfg), .strb(strb), .txWdata(busWdata[WORD_W-1:0]),
    .miso(miso), .sclk(sclk), .mosi(mosi), .rxRdata(rxRdata), .txLevel(txLevel),
    .rxLevel(rxLevel), .busy(busy), .wordDone(wordDone));
endmodule

// File: rtl/spi_master_chk.sv
module spi_master_chk
  import spi_master_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  localparam int LW = $clog2(FIFO_DEPTH + 1)
) (
  input logic          clk,
  input logic          rstN,
  input logic          busWe,
  input logic          busRe,
  input logic [5:0]    busAddr,
  input logic [31:0]   busRdata,
  input logic          sclk,
  input logic          csN,
  input logic          cpol,
  input logic          busy,
  input spiStrobe_t    strb,
  input logic [LW-1:0] txLevel,
  input logic [LW-1:0] rxLevel
);
  // R6
  level_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txLevel <= LW'(FIFO_DEPTH)) && (rxLevel <= LW'(FIFO_DEPTH)));
  // R6
  tx_room_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.txPush |-> txLevel < LW'(FIFO_DEPTH));
  // R10
  rx_room_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.rxPush |-> rxLevel < LW'(FIFO_DEPTH));
  // R10
  tx_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.txPop |-> (strb.wordStart && txLevel != '0));
  // R10
  start_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.wordStart |-> !busy);
  // R7
  underrun_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busRe && busAddr[5:2] == REG_RXD && rxLevel == '0) |-> busRdata == 32'd0);
  // R13
  cs_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(busWe && busAddr[5:2] == REG_PIN) |=> $stable(csN));
  // R3
  sclk_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && $past(!busy) && $stable(cpol)) |-> sclk == cpol);
endmodule

bind spi_master spi_master_chk #(.FIFO_DEPTH(FIFO_DEPTH)) u_chk (
  .clk(clk), .rstN(rstN), .busWe(busWe), .busRe(busRe), .busAddr(busAddr),
  .busRdata(busRdata), .sclk(sclk), .csN(csN), .cpol(cfg.cpol), .busy(busy),
  .strb(strb), .txLevel(txLevel), .rxLevel(rxLevel));

// File: tb/spi_master_tb.sv
`timescale 1ns/1ps
module spi_master_tb;
  localparam logic [5:0] A_CTRL = 6'h00, A_CFG = 6'h04, A_STAT = 6'h08, A_PIN = 6'h0C;
  localparam logic [5:0] A_TXD = 6'h10, A_RXD = 6'h14, A_DIV = 6'h18;
  localparam logic [5:0] A_TXCNT = 6'h1C, A_RXCNT = 6'h20;

  logic clk = 1'b0, rstN = 1'b0;
  logic busWe = 1'b0, busRe = 1'b0;
  logic [5:0] busAddr = '0;
  logic [31:0] busWdata = '0, busRdata;
  logic miso, sclk, mosi, csN;
  logic misoFlip = 1'b0;
  logic tbCpol = 1'b0, tbCpha = 1'b0;
  int numChecks = 0, numFails = 0;

  always #5 clk = ~clk;
  assign miso = mosi ^ misoFlip;

  spi_master u_dut (.clk(clk), .rstN(rstN), .busWe(busWe), .busRe(busRe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .miso(miso), .sclk(sclk), .mosi(mosi), .csN(csN));

  int edgeCnt = 0;
  logic [31:0] capWord = '0;
  longint lastT = 0, lastHalf = 0;
  always @(sclk) begin
    lastHalf = $time - lastT;
    lastT = $time;
    if (tbCpha ? (sclk == tbCpol) : (sclk != tbCpol)) begin
      capWord = {capWord[30:0], mosi};
      edgeCnt++;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    numChecks++;
    if (!ok) begin
      numFails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    busWe = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    busRe = 1'b1; busAddr = a;
    #1 d = busRdata;
    @(negedge clk);
    busRe = 1'b0;
  endtask

  task automatic waitStat(input logic [31:0] bits, input string req);
    logic [31:0] s;
    int n = 0;
    do begin rd(A_STAT, s); n++; end while (((s & bits) != bits) && n < 5000);
    check((s & bits) == bits, req, s, bits);
  endtask

  function automatic logic [31:0] maskOf(input int n);
    return (n >= 32) ? 32'hFFFF_FFFF : ((32'd1 << n) - 32'd1);
  endfunction

  function automatic logic [31:0] revBits(input logic [31:0] w, input int n);
    logic [31:0] r = '0;
    for (int i = 0; i < n; i++) r[i] = w[n-1-i];
    return r;
  endfunction

  function automatic int lenOf(input int i);
    case (i)
      0: return 1;
      1: return 7;
      2: return 8;
      3: return 13;
      default: return 32;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    numChecks++; numFails++;
    $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'd1, 32'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", numChecks, numFails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [31:0] w [3];
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(csN == 1'b1, "R1 csN", {31'd0, csN}, 32'd1);
    check(sclk == 1'b0, "R1 sclk", {31'd0, sclk}, 32'd0);
    rd(A_STAT, d); check(d == 32'h0010_0000, "R1 status", d, 32'h0010_0000);

    // R13 chip-select
    wr(A_PIN, 32'd0); check(csN == 1'b0, "R13 csN low", {31'd0, csN}, 32'd0);
    wr(A_PIN, 32'd1); check(csN == 1'b1, "R13 csN high", {31'd0, csN}, 32'd1);

    // Sweep: R2 R3 R4 R5 R9 R11
    for (int m = 0; m < 4; m++) begin
      for (int o = 0; o < 2; o++) begin
        for (int li = 0; li < 5; li++) begin
          int n, dv, e0;
          logic [31:0] msk, expCap;
          n = lenOf(li);
          dv = 1 + ((m + o + li) % 3);
          msk = maskOf(n);
          tbCpha = m[0]; tbCpol = m[1];
          wr(A_CTRL, 32'hC);
          wr(A_CFG, (n << 8) | (o << 2) | (m[1] << 1) | m[0]);
          wr(A_DIV, dv);
          wr(A_STAT, 32'hF);
          wr(A_TXCNT, 3); wr(A_RXCNT, 3);
          for (int k = 0; k < 3; k++) begin
            w[k] = (32'h9E37_79B9 * (k + 1 + m * 7 + li * 3 + o * 11)) ^ 32'h5A5A_0F0F;
            wr(A_TXD, w[k]);
          end
          repeat (3) @(negedge clk);
          e0 = edgeCnt;
          repeat (20) @(negedge clk);
          check(edgeCnt == e0, "R11 no shift before run", edgeCnt - e0, 0);
          wr(A_CTRL, 32'd1);
          waitStat(32'h3, "R9 both done");
          check(edgeCnt - e0 == 3 * n, "R2 edge count", edgeCnt - e0, 3 * n);
          check(lastHalf == 10 * dv, "R5 half period", 32'(lastHalf), 32'(10 * dv));
          expCap = o ? revBits(w[2], n) : (w[2] & msk);
          check((capWord & msk) == expCap, "R4 bit order", capWord & msk, expCap);
          check(sclk == m[1], "R3 idle level", {31'd0, sclk}, {31'd0, m[1]});
          for (int k = 0; k < 3; k++) begin
            rd(A_RXD, d);
            check(d == (w[k] & msk), "R2 loopback word", d, w[k] & msk);
          end
          wr(A_CTRL, 32'd0);
        end
      end
    end

    tbCpha = 1'b0; tbCpol = 1'b0;
    wr(A_CFG, 32'h0800); wr(A_DIV, 1); wr(A_CTRL, 32'hC); wr(A_STAT, 32'hF);

    // R6 overflow, R12 reset, R9 clear
    for (int k = 0; k < 17; k++) wr(A_TXD, k);
    rd(A_STAT, d); check(d == 32'h0010_1014, "R6 full and overflow", d, 32'h0010_1014);
    wr(A_CTRL, 32'h4);
    rd(A_STAT, d); check(d == 32'h0010_0004, "R12 tx reset", d, 32'h0010_0004);
    wr(A_STAT, 32'h4);
    rd(A_STAT, d); check(d == 32'h0010_0000, "R9 write-one clear", d, 32'h0010_0000);

    // R7 underrun
    rd(A_RXD, d); check(d == 32'd0, "R7 empty read", d, 32'd0);
    rd(A_STAT, d); check(d == 32'h0010_0008, "R7 underrun flag", d, 32'h0010_0008);
    wr(A_STAT, 32'hF);

    // R8 tx only: rx bits dropped
    wr(A_TXCNT, 2); wr(A_RXCNT, 0); wr(A_TXD, 32'h5A); wr(A_TXD, 32'hA5);
    wr(A_CTRL, 32'd1);
    waitStat(32'h1, "R9 tx done");
    repeat (5) @(negedge clk);
    rd(A_STAT, d); check(d == 32'h0010_0001, "R8 rx disabled", d, 32'h0010_0001);
    wr(A_CTRL, 32'd0); wr(A_STAT, 32'hF);

    // R8 tx exhausted before rx: mosi sends 0
    wr(A_TXCNT, 1); wr(A_RXCNT, 3); wr(A_TXD, 32'hC3);
    wr(A_CTRL, 32'd1);
    waitStat(32'h2, "R9 rx done");
    rd(A_STAT, d); check(d == 32'h0300_0003, "R8 status", d, 32'h0300_0003);
    rd(A_RXD, d); check(d == 32'hC3, "R8 first word", d, 32'hC3);
    rd(A_RXD, d); check(d == 32'h0, "R8 idle mosi word", d, 32'h0);
    rd(A_RXD, d); check(d == 32'h0, "R8 idle mosi word", d, 32'h0);
    wr(A_CTRL, 32'd0); wr(A_STAT, 32'hF);

    // R10 stall with full RX, then concurrent drain
    misoFlip = 1'b1;
    wr(A_TXCNT, 0); wr(A_RXCNT, 20); wr(A_CTRL, 32'd1);
    repeat (800) @(negedge clk);
    rd(A_STAT, d); check(d == 32'h1000_0000, "R10 stalled full", d, 32'h1000_0000);
    check(sclk == 1'b0, "R10 sclk idle in stall", {31'd0, sclk}, 32'd0);
    for (int k = 0; k < 16; k++) begin
      rd(A_RXD, d); check(d == 32'hFF, "R10 drained word", d, 32'hFF);
    end
    waitStat(32'h2, "R10 resumes to done");
    rd(A_STAT, d); check(d == 32'h0400_0002, "R10 final level", d, 32'h0400_0002);
    for (int k = 0; k < 4; k++) begin
      rd(A_RXD, d); check(d == 32'hFF, "R10 tail word", d, 32'hFF);
    end
    misoFlip = 1'b0;
    wr(A_CTRL, 32'hC); wr(A_STAT, 32'hF);

    // R11 clearing run finishes current word only
    wr(A_DIV, 4); wr(A_TXCNT, 4); wr(A_RXCNT, 0);
    for (int k = 0; k < 4; k++) wr(A_TXD, k + 1);
    wr(A_CTRL, 32'd1);
    repeat (20) @(negedge clk);
    wr(A_CTRL, 32'd0);
    repeat (300) @(negedge clk);
    rd(A_STAT, d); check(d == 32'h0010_0300, "R11 stop after word", d, 32'h0010_0300);
    check(sclk == 1'b0, "R11 sclk idle", {31'd0, sclk}, 32'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", numChecks, numFails);
    $finish;
  end
endmodule